// File: doc/BRIEF.md
# Floating-Point Halved Subtractor

This unit takes two IEEE-754 operands `a` and `b` and returns `(a - b) / 2` with a single rounding step. The division by two never becomes a separate rounding: it is a one-step exponent decrement applied before normalisation. A difference that lands in the subnormal range is therefore rounded only once. The default build is binary16. The exponent and fraction widths are parameters, so binary32 and binary64 come from the same code.

The operands are sampled on a rising clock edge, and the result and flags are registered at that same edge. Each operation carries its own control bits:
- a two-bit rounding mode;
- a flush-to-zero enable;
- a default-NaN enable.

The four exception flags describe only the operation whose result sits beside them. Accumulating them is the consumer's job.

Top module: `fp_halved_sub`

## Requirements
- R1: Result and flags are registered. Inputs applied before a rising edge appear on the outputs after that edge. While `rst` is high at an edge, the result and all four flags become 0.
- R2: NaN inputs are resolved before every other rule.
  - Any signaling NaN (exponent all ones, fraction MSB 0, fraction nonzero) raises invalid.
  - With `dnan_en` set, the result is the canonical quiet NaN (binary16 0x7E00).
  - Otherwise, in priority order: a signaling `a`, a signaling `b`, a quiet `a`, a quiet `b`. The chosen operand is returned with fraction MSB forced to 1.
- R3: Two infinities of equal sign give 0x7E00 and raise invalid, whatever `dnan_en` is.
- R4: Outside R3, if `a` is +inf or `b` is -inf, the result is +inf (0x7C00). Otherwise, if `a` is -inf or `b` is +inf, the result is -inf (0xFC00). No flag is raised.
- R5: Two zero operands of opposite sign give a zero that carries the sign of `a`, with no flags.
- R6: For all other operands the exact value (a-b)/2 is rounded once. `rnd_mode` selects the rounding: 00 nearest-even, 01 toward +inf, 10 toward -inf, 11 toward zero. Inexact is raised when the rounded value differs from the exact value.
- R7: An exact zero difference returns -0 under mode 10 and +0 under every other mode, even when neither operand is zero.
- R8: Without flush, a result whose exact magnitude is below the smallest normal is rounded once to a subnormal or zero. Underflow is raised exactly when such a result is also inexact.
- R9: With `flush_en` set:
  - subnormal inputs act as zeros of their own sign;
  - a result whose exact magnitude is below the smallest normal becomes a zero with the result's sign;
  - in that case underflow is raised and inexact is cleared.
- R10: Overflow is raised only when rounding would carry into the all-ones exponent. A halved difference of finite operands cannot reach this, so the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | EXP_W+MAN_W+1 | Minuend |
| op_b | input | EXP_W+MAN_W+1 | Subtrahend |
| rnd_mode | input | 2 | Rounding mode (R6 encoding) |
| flush_en | input | 1 | Flush subnormal inputs and results to zero |
| dnan_en | input | 1 | Return the canonical NaN for NaN inputs |
| res | output | EXP_W+MAN_W+1 | Registered halved difference |
| flg_invalid | output | 1 | Invalid operation for this result |
| flg_overflow | output | 1 | Overflow for this result |
| flg_underflow | output | 1 | Underflow for this result |
| flg_inexact | output | 1 | Inexact for this result |

## Verification
The hardest situation to reach is a deep cancellation whose halved result crosses into the subnormal range just as a rounding tie or a carry into the smallest normal occurs. Uniform operand pairs almost never cancel that closely. A second sweep therefore builds `b` from `a` by flipping only its low fraction bits or by stepping its encoding up or down by a few units, and varies the rounding mode and flush enable from vector to vector. A structured cross product complements it: every sign and exponent is paired with a zero, minimum, quiet-NaN-like and all-ones fraction, so that every special-operand pairing occurs under every control setting.

// File: rtl/fphs_pkg.sv
package fphs_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_UP   = 2'b01,
        RM_DOWN = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic inf;
        logic nan;
        logic snan;
    } opclass_t;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } fpflags_t;

    // Increment decision for the kept significand.
    function automatic logic round_inc(rmode_e m, logic sign, logic lsb, logic guard, logic sticky);
        case (m)
            RM_NEAR: return guard & (sticky | lsb);
            RM_UP:   return ~sign & (guard | sticky);
            RM_DOWN: return sign & (guard | sticky);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fphs_unpack.sv
module fphs_unpack #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic [EXP_W+MAN_W:0]  op,
    input  logic                  flush,
    output fphs_pkg::opclass_t    cls,
    output logic [EXP_W-1:0]      eff_exp,
    output logic [MAN_W:0]        sig
);
    logic [EXP_W-1:0] e_fld;
    logic [MAN_W-1:0] m_fld;
    logic e_max, e_min, m_any;

    assign e_fld = op[MAN_W +: EXP_W];
    assign m_fld = op[MAN_W-1:0];
    assign e_max = &e_fld;
    assign e_min = ~|e_fld;
    assign m_any = |m_fld;

    always_comb begin
        cls.sign = op[EXP_W+MAN_W];
        cls.zero = e_min & (~m_any | flush);
        cls.inf  = e_max & ~m_any;
        cls.nan  = e_max & m_any;
        cls.snan = e_max & m_any & ~m_fld[MAN_W-1];
        eff_exp  = e_min ? EXP_W'(1) : e_fld;
        sig      = cls.zero ? '0 : {~e_min, m_fld};
    end
endmodule

// File: rtl/fphs_special.sv
module fphs_special #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  fphs_pkg::opclass_t   cls_a,
    input  fphs_pkg::opclass_t   cls_b,
    input  logic                 dnan,
    output logic                 hit,
    output logic [EXP_W+MAN_W:0] val,
    output logic                 invalid
);
    localparam int W = EXP_W + MAN_W + 1;
    localparam logic [W-1:0] QBIT   = W'(1) << (MAN_W - 1);
    localparam logic [W-1:0] INF_P  = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    localparam logic [W-1:0] DEF_NAN = INF_P | QBIT;

    always_comb begin
        hit     = 1'b1;
        invalid = 1'b0;
        val     = '0;
        if (cls_a.nan | cls_b.nan) begin
            invalid = cls_a.snan | cls_b.snan;
            if (dnan)            val = DEF_NAN;
            else if (cls_a.snan) val = op_a | QBIT;
            else if (cls_b.snan) val = op_b | QBIT;
            else if (cls_a.nan)  val = op_a;
            else                 val = op_b;
        end else if (cls_a.inf & cls_b.inf & (cls_a.sign == cls_b.sign)) begin
            invalid = 1'b1;
            val     = DEF_NAN;
        end else if ((cls_a.inf & ~cls_a.sign) | (cls_b.inf & cls_b.sign)) begin
            val = INF_P;
        end else if ((cls_a.inf & cls_a.sign) | (cls_b.inf & ~cls_b.sign)) begin
            val = INF_P | (W'(1) << (W - 1));
        end else if (cls_a.zero & cls_b.zero & (cls_a.sign != cls_b.sign)) begin
            val = {cls_a.sign, {(W-1){1'b0}}};
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/fphs_core.sv
module fphs_core #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic                 sign_a,
    input  logic [EXP_W-1:0]     exp_a,
    input  logic [MAN_W:0]       sig_a,
    input  logic                 sign_b,
    input  logic [EXP_W-1:0]     exp_b,
    input  logic [MAN_W:0]       sig_b,
    input  fphs_pkg::rmode_e     rmode,
    input  logic                 flush,
    output logic [EXP_W+MAN_W:0] res,
    output fphs_pkg::fpflags_t   flags
);
    import fphs_pkg::*;

    localparam int SIG_W = MAN_W + 1;
    localparam int GRD_W = SIG_W + 2;
    localparam int ACC_W = 1 + SIG_W + GRD_W;
    localparam int POS_W = $clog2(ACC_W) + 1;
    localparam int PK_W  = EXP_W + MAN_W;

    logic                 eff_sb, a_big, r_sign, do_add;
    logic [EXP_W-1:0]     e_hi, e_lo, e_diff;
    logic [SIG_W-1:0]     s_hi, s_lo;
    logic [ACC_W-1:0]     hi_ext, lo_ext, lo_shift, acc, left, den;
    logic                 lo_lost, d_lost;
    logic [POS_W-1:0]     lead;
    int                   norm_e, dn;
    logic                 tiny, guard, stk, inc, ovf;
    logic [EXP_W-1:0]     exp_fld;
    logic [PK_W:0]        rnd;

    // Order operands by magnitude; a - b is a + (-b).
    always_comb begin
        eff_sb = ~sign_b;
        a_big  = {exp_a, sig_a} >= {exp_b, sig_b};
        do_add = (sign_a == eff_sb);
        e_hi   = a_big ? exp_a  : exp_b;
        e_lo   = a_big ? exp_b  : exp_a;
        s_hi   = a_big ? sig_a  : sig_b;
        s_lo   = a_big ? sig_b  : sig_a;
        r_sign = a_big ? sign_a : eff_sb;
        e_diff = e_hi - e_lo;
    end

    // Alignment with sticky collection.
    always_comb begin
        hi_ext = {1'b0, s_hi, {GRD_W{1'b0}}};
        lo_ext = {1'b0, s_lo, {GRD_W{1'b0}}};
        if (int'(e_diff) >= ACC_W) begin
            lo_shift = '0;
            lo_lost  = |lo_ext;
        end else begin
            lo_shift = lo_ext >> e_diff;
            lo_lost  = |(lo_ext & ~({ACC_W{1'b1}} << e_diff));
        end
        if (do_add) acc = hi_ext + (lo_shift | {{(ACC_W-1){1'b0}}, lo_lost});
        else        acc = hi_ext - (lo_shift | {{(ACC_W-1){1'b0}}, lo_lost});
    end

    // Leading-one position.
    always_comb begin
        lead = '0;
        for (int i = 0; i < ACC_W; i++) begin
            if (acc[i]) lead = POS_W'(i);
        end
    end

    // Exponent with the halving folded in (one less than the unhalved value).
    always_comb begin
        norm_e = int'(e_hi) + int'(lead) - (ACC_W - 1);
        tiny   = norm_e < 1;
        dn     = tiny ? (1 - norm_e) : 0;
        left   = acc << (POS_W'(ACC_W - 1) - lead);
        if (dn >= ACC_W) begin
            den    = '0;
            d_lost = |left;
        end else begin
            den    = left >> dn;
            d_lost = |(left & ~({ACC_W{1'b1}} << dn));
        end
        guard   = den[ACC_W-1-SIG_W];
        stk     = (|den[ACC_W-2-SIG_W:0]) | d_lost;
        exp_fld = tiny ? '0 : norm_e[EXP_W-1:0];
        inc     = round_inc(rmode, r_sign, den[ACC_W-SIG_W], guard, stk);
        rnd     = {1'b0, exp_fld, den[ACC_W-2 -: MAN_W]} + (PK_W+1)'(inc);
        ovf     = rnd[PK_W] | (&rnd[MAN_W +: EXP_W]);
    end

    // Result selection.
    always_comb begin
        flags = '0;
        if (acc == '0) begin
            res = {rmode == RM_DOWN, {PK_W{1'b0}}};
        end else if (flush & tiny) begin
            res             = {r_sign, {PK_W{1'b0}}};
            flags.underflow = 1'b1;
        end else if (ovf) begin
            flags.overflow = 1'b1;
            flags.inexact  = 1'b1;
            if (rmode == RM_NEAR || (rmode == RM_UP && !r_sign) || (rmode == RM_DOWN && r_sign))
                res = {r_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            else
                res = {r_sign, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
        end else begin
            res             = {r_sign, rnd[PK_W-1:0]};
            flags.inexact   = guard | stk;
            flags.underflow = tiny & (guard | stk);
        end
    end
endmodule

// File: rtl/fp_halved_sub.sv
module fp_halved_sub #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  logic [1:0]           rnd_mode,
    input  logic                 flush_en,
    input  logic                 dnan_en,
    output logic [EXP_W+MAN_W:0] res,
    output logic                 flg_invalid,
    output logic                 flg_overflow,
    output logic                 flg_underflow,
    output logic                 flg_inexact
);
    import fphs_pkg::*;

    localparam int W = EXP_W + MAN_W + 1;

    logic [W-1:0]     ops [2];
    opclass_t         cls [2];
    logic [EXP_W-1:0] eexp [2];
    logic [MAN_W:0]   esig [2];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar k = 0; k < 2; k++) begin : g_unp
        fphs_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_unp (
            .op(ops[k]), .flush(flush_en), .cls(cls[k]),
            .eff_exp(eexp[k]), .sig(esig[k])
        );
    end

    logic         sp_hit, sp_inv;
    logic [W-1:0] sp_val, ar_val;
    fpflags_t     ar_flags;

    fphs_special #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_spec (
        .op_a(op_a), .op_b(op_b), .cls_a(cls[0]), .cls_b(cls[1]),
        .dnan(dnan_en), .hit(sp_hit), .val(sp_val), .invalid(sp_inv)
    );

    fphs_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_core (
        .sign_a(cls[0].sign), .exp_a(eexp[0]), .sig_a(esig[0]),
        .sign_b(cls[1].sign), .exp_b(eexp[1]), .sig_b(esig[1]),
        .rmode(rmode_e'(rnd_mode)), .flush(flush_en),
        .res(ar_val), .flags(ar_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res           <= '0;
            flg_invalid   <= 1'b0;
            flg_overflow  <= 1'b0;
            flg_underflow <= 1'b0;
            flg_inexact   <= 1'b0;
        end else if (sp_hit) begin
            res           <= sp_val;
            flg_invalid   <= sp_inv;
            flg_overflow  <= 1'b0;
            flg_underflow <= 1'b0;
            flg_inexact   <= 1'b0;
        end else begin
            res           <= ar_val;
            flg_invalid   <= 1'b0;
            flg_overflow  <= ar_flags.overflow;
            flg_underflow <= ar_flags.underflow;
            flg_inexact   <= ar_flags.inexact;
        end
    end
endmodule

// File: rtl/fphs_checker.sv
module fphs_checker #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input logic                 clk,
    input logic                 rst,
    input logic [EXP_W+MAN_W:0] op_a,
    input logic [EXP_W+MAN_W:0] op_b,
    input logic [1:0]           rnd_mode,
    input logic                 flush_en,
    input logic                 dnan_en,
    input logic [EXP_W+MAN_W:0] res,
    input logic                 flg_invalid,
    input logic                 flg_overflow,
    input logic                 flg_underflow,
    input logic                 flg_inexact
);
    localparam int W = EXP_W + MAN_W + 1;
    localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic a_nan, b_nan, a_inf, b_inf, a_sub, b_sub;
    assign a_nan = (&op_a[MAN_W +: EXP_W]) & (|op_a[MAN_W-1:0]);
    assign b_nan = (&op_b[MAN_W +: EXP_W]) & (|op_b[MAN_W-1:0]);
    assign a_inf = (&op_a[MAN_W +: EXP_W]) & ~(|op_a[MAN_W-1:0]);
    assign b_inf = (&op_b[MAN_W +: EXP_W]) & ~(|op_b[MAN_W-1:0]);
    assign a_sub = ~(|op_a[MAN_W +: EXP_W]);
    assign b_sub = ~(|op_b[MAN_W +: EXP_W]);

    assert_dnan_R2: assert property (@(posedge clk) disable iff (rst)
        ((a_nan | b_nan) & dnan_en) |=> (res == DEF_NAN));

    assert_no_invalid_R2: assert property (@(posedge clk) disable iff (rst)
        !(a_nan | b_nan | a_inf | b_inf) |=> !flg_invalid);

    assert_inf_same_R3: assert property (@(posedge clk) disable iff (rst)
        (a_inf & b_inf & (op_a[W-1] == op_b[W-1])) |=> (res == DEF_NAN && flg_invalid));

    assert_exact_zero_R7: assert property (@(posedge clk) disable iff (rst)
        ((op_a == op_b) & !a_nan & !a_inf) |=>
            (res == {$past(rnd_mode) == 2'b10, {(W-1){1'b0}}} && !flg_inexact));

    assert_ftz_inputs_R9: assert property (@(posedge clk) disable iff (rst)
        (flush_en & a_sub & b_sub) |=> (res[W-2:0] == '0 && !flg_underflow));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        !flg_overflow);

    assert_flag_excl_R2: assert property (@(posedge clk) disable iff (rst)
        flg_invalid |-> (!flg_inexact && !flg_underflow));
endmodule

bind fp_halved_sub fphs_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_chk (.*);

// File: tb/test_fp_halved_sub.sv
module test_fp_halved_sub;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_a = '0, op_b = '0;
    logic [1:0]  rnd_mode = '0;
    logic        flush_en = 1'b0, dnan_en = 1'b0;
    logic [15:0] res;
    logic        flg_invalid, flg_overflow, flg_underflow, flg_inexact;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fp_halved_sub i_fp_halved_sub (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .rnd_mode(rnd_mode),
        .flush_en(flush_en), .dnan_en(dnan_en), .res(res),
        .flg_invalid(flg_invalid), .flg_overflow(flg_overflow),
        .flg_underflow(flg_underflow), .flg_inexact(flg_inexact)
    );

    function automatic real pw2(int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic real h2r(logic [15:0] h, bit ftz);
        int  e = int'(h[14:10]);
        int  m = int'(h[9:0]);
        real mag;
        if (e == 0) mag = ftz ? 0.0 : m * pw2(-24);
        else        mag = (1024 + m) * pw2(e - 25);
        return h[15] ? -mag : mag;
    endfunction

    // Reference model: flags are {invalid, overflow, underflow, inexact}.
    task automatic model(input logic [15:0] a, input logic [15:0] b, input logic [1:0] rm,
                         input bit ftz, input bit dn,
                         output logic [15:0] r, output logic [3:0] fl, output string tag);
        bit  an, bn, asn, bsn, ai, bi, az, bz, s, tiny, up, inx, unf;
        real v, m, qt, qv, fr;
        int  e, ip;
        an  = (a[14:10] == 5'h1F) && (a[9:0] != 0);
        bn  = (b[14:10] == 5'h1F) && (b[9:0] != 0);
        asn = an && !a[9];
        bsn = bn && !b[9];
        ai  = (a[14:10] == 5'h1F) && (a[9:0] == 0);
        bi  = (b[14:10] == 5'h1F) && (b[9:0] == 0);
        az  = (a[14:10] == 0) && (a[9:0] == 0 || ftz);
        bz  = (b[14:10] == 0) && (b[9:0] == 0 || ftz);
        fl  = '0;
        if (an || bn) begin
            tag   = "R2";
            fl[3] = asn || bsn;
            if (dn)       r = 16'h7E00;
            else if (asn) r = a | 16'h0200;
            else if (bsn) r = b | 16'h0200;
            else if (an)  r = a;
            else          r = b;
        end else if (ai && bi && a[15] == b[15]) begin
            tag = "R3"; r = 16'h7E00; fl[3] = 1'b1;
        end else if ((ai && !a[15]) || (bi && b[15])) begin
            tag = "R4"; r = 16'h7C00;
        end else if ((ai && a[15]) || (bi && !b[15])) begin
            tag = "R4"; r = 16'hFC00;
        end else if (az && bz && a[15] != b[15]) begin
            tag = "R5"; r = {a[15], 15'h0};
        end else begin
            v = (h2r(a, ftz) - h2r(b, ftz)) / 2.0;
            if (v == 0.0) begin
                tag = "R7"; r = {rm == 2'b10, 15'h0};
            end else begin
                s = v < 0.0;
                m = s ? -v : v;
                e = 0;
                while (m >= pw2(e + 1)) e++;
                while (m < pw2(e)) e--;
                tiny = e < -14;
                qt   = tiny ? pw2(-24) : pw2(e - 10);
                qv   = m / qt;
                ip   = $rtoi(qv);
                fr   = qv - ip;
                case (rm)
                    2'b00:   up = (fr > 0.5) || (fr == 0.5 && (ip % 2) == 1);
                    2'b01:   up = !s && fr > 0.0;
                    2'b10:   up = s && fr > 0.0;
                    default: up = 1'b0;
                endcase
                ip  = ip + int'(up);
                inx = fr > 0.0;
                if (ftz && tiny) begin
                    tag = "R9"; r = {s, 15'h0}; unf = 1'b1; inx = 1'b0;
                end else begin
                    if (tiny) r = {s, 15'(ip)};
                    else begin
                        if (ip == 2048) begin e++; ip = 1024; end
                        r = {s, 5'(e + 15), 10'(ip - 1024)};
                    end
                    unf = tiny && inx;
                    tag = tiny ? "R8" : (ftz ? "R9" : "R6");
                end
                fl[1] = unf;
                fl[0] = inx;
            end
        end
    endtask

    logic [15:0] exp_r;
    logic [3:0]  exp_f;
    string       exp_tag;
    logic [15:0] prev_a, prev_b;
    bit          pend = 0;

    task automatic compare();
        logic [3:0] got_f;
        got_f  = {flg_invalid, flg_overflow, flg_underflow, flg_inexact};
        checks = checks + 1;
        if (res !== exp_r || got_f !== exp_f) begin
            errors = errors + 1;
            $display("FAIL %s%s a=%h b=%h: got %h flags %b, expected %h flags %b",
                     exp_tag, flg_overflow ? "/R10" : "", prev_a, prev_b, res, got_f, exp_r, exp_f);
        end
    endtask

    // Drive one vector per cycle; check the previous one (R1 latency of one edge).
    task automatic step(input logic [15:0] a, input logic [15:0] b, input logic [1:0] rm,
                        input bit ftz, input bit dn);
        @(negedge clk);
        if (pend) compare();
        op_a = a; op_b = b; rnd_mode = rm; flush_en = ftz; dnan_en = dn;
        prev_a = a; prev_b = b;
        model(a, b, rm, ftz, dn, exp_r, exp_f, exp_tag);
        pend = 1;
    endtask

    function automatic logic [15:0] opv(int k);
        logic [9:0] m;
        case (k & 3)
            0: m = 10'h000;
            1: m = 10'h001;
            2: m = 10'h200;
            default: m = 10'h3FF;
        endcase
        return {k[7], k[6:2], m};
    endfunction

    task automatic check_reset_zero(input string what);
        checks = checks + 1;
        if (res !== 16'h0 || {flg_invalid, flg_overflow, flg_underflow, flg_inexact} !== 4'b0) begin
            errors = errors + 1;
            $display("FAIL R1 %s: got %h flags %b, expected 0000 flags 0000", what, res,
                     {flg_invalid, flg_overflow, flg_underflow, flg_inexact});
        end
    endtask

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_zero("initial reset");
        rst = 1'b0;

        // R2..R10: structured cross product of sign, exponent and fraction classes.
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                step(opv(i), opv(j), 2'((i + j) & 3), ((i * 7 + j * 3) % 5) == 0,
                     ((i + 2 * j) % 3) == 0);
            end
        end

        // R6, R7, R8, R9: near-cancellation pairs.
        lf = 16'hACE1;
        for (int n = 0; n < 16384; n++) begin
            logic [15:0] bb;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (n % 3)
                0: bb = lf ^ {11'h0, 5'(n)};
                1: bb = lf + 16'(n % 7);
                default: bb = lf - 16'(n % 5);
            endcase
            step(lf, bb, 2'(n & 3), n[2], n[3]);
        end

        // R1: reset clears a non-zero output.
        step(16'h3C00, 16'hC000, 2'b00, 1'b0, 1'b0);
        @(negedge clk);
        compare();
        pend = 0;
        rst  = 1'b1;
        @(negedge clk);
        check_reset_zero("reset after activity");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R1 watchdog expired: got running, expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule